// File: doc/BRIEF.md
# Receive Byte Window Buffer

This block sits behind the deserializer of a fast serial port and holds received bytes until host software collects them. Bytes arrive one per cycle on a valid/data pair and are appended in arrival order. Software never pops bytes one at a time. It reads a memory-mapped window whose first byte is always the oldest byte not yet consumed, copies as much as it needs, and then returns a whole block of storage with one write of a byte count.

Two request outputs tell software when to act. The level request is raised while the number of stored bytes is at or above a threshold chosen by a 3-bit level field. The idle request is raised when a few bytes have been sitting below that threshold and nothing has arrived or been released for a programmable number of bit-clock ticks. A sticky flag records any byte lost because the storage was already full.

Top module: `rx_window_buf`

## Requirements
- R1: After reset the fill count is 0, the trigger level is 6, both request outputs and the loss flag are low, and the register read data is 0.
- R2: A read of address 0x000 returns the status word: fill count bits 7:0 in bits 31:24, fill count bits 9:8 in bits 7:6, the loss flag in bit 3, the idle request in bit 2, the level request in bit 1, and zero in every other bit. Read data appears one cycle after the read strobe.
- R3: A read of an address A from 0x004 to 0x3FF (low two address bits ignored) returns bytes k to k+3 of the unread data, where k = (A rounded down to a multiple of 4) - 4, byte 0 being the oldest; byte k+j sits in bits 8j+7:8j, and any byte at or beyond the fill count reads as 0.
- R4: The window ends at 0x3FF, so at most 1020 bytes can be read in one pass; addresses from 0x400 to 0x7FF and any other unused address read as 0.
- R5: A write of N to address 0x800 (count in bits 10:0) consumes the N oldest bytes: the fill count drops by N and window offset 0 then shows the byte that was N-th oldest.
- R6: A release count larger than the fill count is clamped to the fill count, and later bytes are still stored and read back in order.
- R7: The storage holds at most 1023 bytes; a byte arriving while it is full is dropped, sets the loss flag, and leaves the fill count at 1023.
- R8: The loss flag stays set until a status read, which still reports it as set and clears it afterwards.
- R9: The trigger level is bits 22:20 of the configuration register at 0x808 (read back in the same bits); the threshold is 4 shifted left by the level, and the level request is high exactly while the fill count is at or above it.
- R10: The idle request rises once TIMEOUT bit-clock ticks have passed with a non-zero fill below the threshold and no arrival or release; a byte arrival drops it and restarts the count.
- R11: A release write drops the idle request and restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit time, paces the idle count |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| rx_avail_req | output | 1 | Fill count at or above the trigger threshold |
| rx_idle_req | output | 1 | Data idle below the threshold for TIMEOUT ticks |
| overrun | output | 1 | Sticky flag: a byte was lost to a full buffer |

## Verification
The bench keeps the full 10-bit address width, so the storage really fills to 1023 bytes, the window reaches its last word at 0x3FC, and the split fill field uses both of its parts. TIMEOUT is set to 8 ticks, which brings the idle request within a few operations so random traffic crosses it often and the directed checks can stand one tick before and at the limit. Trigger levels are rewritten during the run, so the level request is seen at the 4-byte boundary as well as at the reset level of 256.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam logic [11:0] A_STATUS  = 12'h000;
    localparam logic [11:0] A_WIN_LO  = 12'h004;
    localparam logic [11:0] A_WIN_HI  = 12'h3FF;
    localparam logic [11:0] A_RELEASE = 12'h800;
    localparam logic [11:0] A_CONFIG  = 12'h808;

    typedef struct packed {
        logic ovr;
        logic idle;
        logic avail;
    } rx_flags_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_WINDOW,
        SEL_CONFIG
    } rd_sel_e;

    // Threshold in bytes for a 3-bit trigger level.
    function automatic logic [10:0] trig_threshold(input logic [2:0] lvl);
        return 11'd4 << lvl;
    endfunction

    // Status word: fill split into high and low parts around the flags.
    function automatic logic [31:0] pack_status(input logic [9:0] fill,
                                                input rx_flags_t f);
        return {fill[7:0], 16'h0000, fill[9:8], 2'b00,
                f.ovr, f.idle, f.avail, 1'b0};
    endfunction

endpackage

// File: rtl/rxw_mem.sv
module rxw_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rbase,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Four byte lanes, each reading the cell after the previous one.
    for (genvar j = 0; j < 4; j++) begin : g_lane
        logic [ADDR_W-1:0] idx;
        assign idx = rbase + ADDR_W'(j);
        assign rdata[8*j +: 8] = cells[idx];
    end
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_in,
    input  logic              rel_en,
    input  logic [ADDR_W:0]   rel_cnt,
    input  logic              ovr_clr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] fill,
    output logic              push_ok,
    output logic              ovr
);
    localparam int CW = ADDR_W + 1;

    logic              full;
    logic [ADDR_W-1:0] rel_n;

    assign full    = &fill;
    assign push_ok = push_in && !full;

    always_comb begin
        rel_n = '0;
        if (rel_en) begin
            if (rel_cnt > CW'(fill)) rel_n = fill;
            else                     rel_n = rel_cnt[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovr    <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + ADDR_W'(push_ok);
            rd_ptr <= rd_ptr + rel_n;
            fill   <= fill + ADDR_W'(push_ok) - rel_n;
            if (push_in && full) ovr <= 1'b1;
            else if (ovr_clr)    ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/rxw_timer.sv
module rxw_timer #(
    parameter int ADDR_W  = 10,
    parameter int TIMEOUT = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              restart,
    input  logic [ADDR_W-1:0] fill,
    input  logic [10:0]       thr,
    output logic              avail,
    output logic              idle
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt;
    logic [10:0]      fill_x;

    assign fill_x = 11'(fill);
    assign avail  = fill_x >= thr;
    assign idle   = (cnt == LIMIT) && (fill != '0) && !avail;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (restart)              cnt <= '0;
        else if (fill == '0)           cnt <= '0;
        else if (bit_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_window_buf.sv
module rx_window_buf
    import rxw_pkg::*;
#(
    parameter int         ADDR_W    = 10,
    parameter int         TIMEOUT   = 40,
    parameter logic [2:0] LEVEL_RST = 3'd6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        bit_tick,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rx_avail_req,
    output logic        rx_idle_req,
    output logic        overrun
);
    localparam int CW = ADDR_W + 1;

    logic [ADDR_W-1:0] wr_ptr, rd_ptr, fill, rbase;
    logic              push_ok, rel_en, cfg_wr, stat_rd;
    logic [2:0]        level;
    logic [11:0]       win_off;
    logic [31:0]       raw_word, win_word;
    rd_sel_e           sel;
    rx_flags_t         flags;

    assign rel_en  = reg_wr && (reg_addr == A_RELEASE);
    assign cfg_wr  = reg_wr && (reg_addr == A_CONFIG);
    assign stat_rd = reg_rd && (reg_addr == A_STATUS);

    rxw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .push_in (rx_valid),
        .rel_en  (rel_en),
        .rel_cnt (reg_wdata[CW-1:0]),
        .ovr_clr (stat_rd),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .fill    (fill),
        .push_ok (push_ok),
        .ovr     (overrun)
    );

    rxw_timer #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .restart  (rx_valid || rel_en),
        .fill     (fill),
        .thr      (trig_threshold(level)),
        .avail    (rx_avail_req),
        .idle     (rx_idle_req)
    );

    // Window offset of the addressed word, relative to the oldest byte.
    assign win_off = {reg_addr[11:2], 2'b00} - A_WIN_LO;
    assign rbase   = rd_ptr + win_off[ADDR_W-1:0];

    rxw_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (rx_data),
        .rbase (rbase),
        .rdata (raw_word)
    );

    // Bytes past the fill count are masked to zero.
    for (genvar j = 0; j < 4; j++) begin : g_mask
        logic [11:0] pos;
        assign pos = win_off + 12'(j);
        assign win_word[8*j +: 8] = (pos < 12'(fill)) ? raw_word[8*j +: 8] : 8'h00;
    end

    always_comb begin
        if (reg_addr == A_STATUS)                              sel = SEL_STATUS;
        else if (reg_addr >= A_WIN_LO && reg_addr <= A_WIN_HI) sel = SEL_WINDOW;
        else if (reg_addr == A_CONFIG)                         sel = SEL_CONFIG;
        else                                                   sel = SEL_NONE;
    end

    assign flags = '{ovr: overrun, idle: rx_idle_req, avail: rx_avail_req};

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            level     <= LEVEL_RST;
        end else begin
            if (cfg_wr) level <= reg_wdata[22:20];
            if (reg_rd) begin
                case (sel)
                    SEL_STATUS: reg_rdata <= pack_status(10'(fill), flags);
                    SEL_WINDOW: reg_rdata <= win_word;
                    SEL_CONFIG: reg_rdata <= {9'b0, level, 20'b0};
                    default:    reg_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              reg_wr,
    input logic [11:0]       reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [ADDR_W-1:0] fill,
    input logic              avail,
    input logic              idle,
    input logic              ovr
);
    logic rel_wr;
    assign rel_wr = reg_wr && (reg_addr == A_RELEASE);

    // R5: a non-zero release on non-empty storage lowers the fill count
    p_release_drop_r5: assert property (@(posedge clk) disable iff (rst)
        rel_wr && (reg_wdata[ADDR_W:0] != '0) && (fill != '0) && !rx_valid
        |=> fill < $past(fill));

    // R5: fill changes only through an arrival or a release
    p_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !rx_valid && !rel_wr |=> $stable(fill));

    // R7: a full buffer stays full when a byte arrives without a release
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (&fill) && rx_valid && !rel_wr |=> (&fill));

    // R7: an arrival on a full buffer sets the loss flag
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        (&fill) && rx_valid |=> ovr);

    // R9, R10: the two requests never stand together
    p_req_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(avail && idle));

    // R10: an arrival restarts the idle count
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !idle);

    // R11: a release restarts the idle count
    p_idle_release_r11: assert property (@(posedge clk) disable iff (rst)
        rel_wr |=> !idle);
endmodule

bind rx_window_buf rxw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .fill      (fill),
    .avail     (rx_avail_req),
    .idle      (rx_idle_req),
    .ovr       (overrun)
);

// File: tb/tb_rx_window_buf.sv
module tb_rx_window_buf;
    localparam int T_OUT = 8;
    localparam int MAXF  = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        bit_tick = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_avail_req, rx_idle_req, overrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [7:0] q[$];
    logic [2:0] m_lvl = 3'd6;
    logic       m_ovr = 1'b0;
    int         m_cnt = 0;

    always #4 clk = ~clk;

    rx_window_buf #(.ADDR_W(10), .TIMEOUT(T_OUT)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .bit_tick(bit_tick), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_avail_req(rx_avail_req), .rx_idle_req(rx_idle_req), .overrun(overrun)
    );

    function automatic bit m_avail();
        return q.size() >= (4 << m_lvl);
    endfunction

    function automatic bit m_idle();
        return (m_cnt == T_OUT) && (q.size() != 0) && !m_avail();
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [9:0]  f;
        logic [31:0] w;
        int          k;
        f = 10'(q.size());
        if (a == 12'h000)
            return {f[7:0], 16'h0000, f[9:8], 2'b00, m_ovr, m_idle(), m_avail(), 1'b0};
        if (a >= 12'h004 && a <= 12'h3FF) begin
            k = int'({a[11:2], 2'b00}) - 4;
            w = '0;
            for (int j = 0; j < 4; j++)
                if (k + j < q.size()) w[8*j +: 8] = q[k + j];
            return w;
        end
        if (a == 12'h808) return {9'b0, m_lvl, 20'b0};
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ports(input string req);
        chk({req, " avail"}, 32'(rx_avail_req), 32'(m_avail()));
        chk({req, " idle"},  32'(rx_idle_req),  32'(m_idle()));
        chk({req, " ovr"},   32'(overrun),      32'(m_ovr));
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
        if (q.size() < MAXF) q.push_back(b);
        else m_ovr = 1'b1;
        m_cnt = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        logic [31:0] e;
        e = exp_read(a);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
        chk(req, reg_rdata, e);
        if (a == 12'h000) m_ovr = 1'b0;
        if (q.size() == 0) m_cnt = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        int n;
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        if (a == 12'h800) begin
            n = int'(d[10:0]);
            if (n > q.size()) n = q.size();
            for (int i = 0; i < n; i++) void'(q.pop_front());
            m_cnt = 0;
        end
        if (a == 12'h808) m_lvl = d[22:20];
        if (q.size() == 0) m_cnt = 0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
            if (q.size() == 0) m_cnt = 0;
            else if (m_cnt < T_OUT) m_cnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk_ports("R1");
        rd_chk("R1 R2 status", 12'h000);
        rd_chk("R1 R9 config", 12'h808);

        // R9: threshold boundary at level 0 (4 bytes)
        wr(12'h808, 32'h0000_0000);
        rd_chk("R9 config readback", 12'h808);
        for (int i = 0; i < 3; i++) push(8'(8'h10 + i));
        chk_ports("R9 below");
        push(8'h13);
        chk_ports("R9 at threshold");
        rd_chk("R3 window word0", 12'h004);
        wr(12'h808, 32'h0060_0000);

        // R10, R11: idle request
        wr(12'h800, 32'd2);
        tick(T_OUT - 1);
        chk_ports("R10 one tick short");
        tick(1);
        chk_ports("R10 at limit");
        rd_chk("R2 R10 status idle", 12'h000);
        push(8'hA5);
        chk_ports("R10 arrival restart");
        tick(T_OUT);
        chk_ports("R10 idle again");
        wr(12'h800, 32'd1);
        chk_ports("R11 release clears");

        // R6: clamp, then R7/R8 full storage
        wr(12'h800, 32'd2047);
        rd_chk("R6 clamp to empty", 12'h000);
        for (int i = 0; i < MAXF; i++) push(8'(i) ^ 8'h5A);
        rd_chk("R2 R7 full status", 12'h000);
        push(8'hEE);
        chk_ports("R7 dropped byte");
        rd_chk("R7 R8 status shows loss", 12'h000);
        rd_chk("R8 loss cleared", 12'h000);
        chk_ports("R8 after clear");
        rd_chk("R4 last window word", 12'h3FC);
        rd_chk("R4 beyond window", 12'h400);
        rd_chk("R4 unused address", 12'h7FC);
        wr(12'h800, 32'd1000);
        rd_chk("R5 window after release", 12'h004);
        rd_chk("R3 partial word masked", 12'h018);
        rd_chk("R3 past fill", 12'h040);
        push(8'h77);
        wr(12'h800, 32'd1500);
        push(8'h42);
        rd_chk("R6 order after clamp", 12'h004);

        // Random mix of traffic, reads, releases and ticks
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0, 1: begin
                    int n;
                    n = int'($urandom % 20) + 1;
                    for (int i = 0; i < n; i++) push(8'($urandom));
                end
                2: rd_chk("R3 random window", 12'((($urandom % 255) + 1) * 4));
                3: wr(12'h800, 32'($urandom % (q.size() + 8)));
                4: rd_chk("R2 random status", 12'h000);
                5: tick(int'($urandom % 10));
                default: wr(12'h808, {9'b0, 3'($urandom), 20'b0});
            endcase
            chk_ports("R9 R10 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule